// File: doc/BRIEF.md
# Register Stack Frame Renamer

This block turns a logical general-register number into a physical register number for a machine whose procedures each see a private window of stacked registers above a fixed set of globals. The register file holds 128 entries. Logical registers 0 to 31 are global and always name the physical register of the same number. The 96 physical registers above them form a circular region, and the active frame starts at a rotating offset in that region. Translation is combinational, so it can sit in the register-read path with no added cycle.

A call strobe gives two values: how many of the caller's registers stay private to the caller (its locals) and the size of the callee's frame. The frame start advances past the caller's locals. The caller's outgoing argument registers therefore become the callee's first registers without any copying. A return strobe gives the same two values for the caller being resumed, and the frame start moves back. The block counts how many registers of older frames still sit in the circular region. When a call would need more room than is free, it raises a spill request. When a return needs caller registers that were already written out, it raises a fill request. In both cases it stalls until the external engine acknowledges the transfer. The memory engine and the register array are outside this block.

Top module: `rsf_renamer`

## Requirements
- R1: After reset the frame start offset is 0, the frame size is 0 and no older registers are resident. `stall_o`, `spill_req_o` and `fill_req_o` are low and `xfer_cnt_o` is 0.
- R2: A logical index below 32 drives `preg_o` equal to the logical index, whatever the frame state.
- R3: A logical index L of 32 or more drives `preg_o` = 32 + ((B + L - 32) mod 96), where B is the current frame start offset (0 to 95). The output is combinational in the same cycle as `lreg_i`.
- R4: `ill_o` is high exactly when `lreg_i` is at least 32 + current frame size. It is low for every index below that limit.
- R5: A call taken with `stall_o` low that fits (resident + `call_keep_i` + `call_size_i` <= 96) takes effect at that clock edge. B becomes (B + keep) mod 96, the frame size becomes `call_size_i` and the resident count grows by keep. The caller's logical register 32+keep+k then names the same physical register as the callee's 32+k.
- R6: A return taken with `stall_o` low and `call_i` low, where `ret_keep_i` <= resident, takes effect at that clock edge. B becomes (B - keep) mod 96, the frame size becomes `ret_size_i` and the resident count shrinks by keep, so the caller's registers map as they did before its call.
- R7: A call that does not fit leaves the frame unchanged. From the next cycle it holds `spill_req_o` and `stall_o` high, with `xfer_cnt_o` = resident + keep + size - 96.
- R8: A return with `ret_keep_i` greater than the resident count leaves the frame unchanged. From the next cycle it holds `fill_req_o` and `stall_o` high, with `xfer_cnt_o` = keep - resident.
- R9: `xfer_ack_i` high while stalled completes the held operation at that edge, with the values captured when the operation was taken. The request and `stall_o` drop, and the resident count drops by the spilled amount or rises by the filled amount.
- R10: While `stall_o` is high, `call_i` and `ret_i` are ignored. When both strobes are high in an idle cycle, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lreg_i | input | 7 | Logical register index to translate |
| preg_o | output | 7 | Physical register index |
| ill_o | output | 1 | Index lies beyond the current frame |
| call_i | input | 1 | Call strobe |
| call_keep_i | input | 7 | Caller registers kept private (start of outgoing arguments) |
| call_size_i | input | 7 | Callee frame size |
| ret_i | input | 1 | Return strobe |
| ret_keep_i | input | 7 | Resumed caller's private register count |
| ret_size_i | input | 7 | Resumed caller's frame size |
| xfer_ack_i | input | 1 | Spill or fill transfer done |
| stall_o | output | 1 | Operation held, strobes ignored |
| spill_req_o | output | 1 | Spill oldest resident registers to memory |
| fill_req_o | output | 1 | Fill caller registers back from memory |
| xfer_cnt_o | output | 7 | Registers to transfer, 0 when idle |

## Verification
The physical index and the illegal flag depend on `lreg_i` in the same cycle. The bench therefore moves `lreg_i` just after a falling edge and reads the result one time step later, before the next rising edge. A call or return changes the mapping at the rising edge that samples its strobe. Spill and fill requests, the transfer count and the stall appear after that same edge. An acknowledge clears them and applies the held frame at the edge that samples it. The behavioural model steps at each rising edge using the inputs held since the previous falling edge, and every output is compared at the following falling edge. Each result is thus checked in the first cycle it is due.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } rsf_state_e;
endpackage

// File: rtl/rsf_map.sv
module rsf_map #(
  parameter int unsigned NUM_REGS   = 128,
  parameter int unsigned NUM_GLOBAL = 32,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic [IW-1:0] lreg_i,
  input  logic [IW-1:0] base_i,
  input  logic [IW-1:0] sof_i,
  output logic [IW-1:0] preg_o,
  output logic          ill_o
);
  localparam logic [IW:0]   STK  = (IW+1)'(NUM_REGS - NUM_GLOBAL);
  localparam logic [IW:0]   GLBW = (IW+1)'(NUM_GLOBAL);
  localparam logic [IW-1:0] GLB  = IW'(NUM_GLOBAL);

  logic [IW-1:0] off;
  logic [IW:0]   pos;

  always_comb begin
    off = lreg_i - GLB;
    pos = {1'b0, base_i} + {1'b0, off};
    if (pos >= STK) pos = pos - STK;
    preg_o = (lreg_i < GLB) ? lreg_i : (pos[IW-1:0] + GLB);
    ill_o  = {1'b0, lreg_i} >= ({1'b0, sof_i} + GLBW);
  end
endmodule

// File: rtl/rsf_frame.sv
module rsf_frame
  import rsf_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 128,
  parameter int unsigned NUM_GLOBAL = 32,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [IW-1:0] call_keep_i,
  input  logic [IW-1:0] call_size_i,
  input  logic          ret_i,
  input  logic [IW-1:0] ret_keep_i,
  input  logic [IW-1:0] ret_size_i,
  input  logic          xfer_ack_i,
  output logic [IW-1:0] base_o,
  output logic [IW-1:0] sof_o,
  output logic [IW-1:0] res_o,
  output logic          stall_o,
  output logic          spill_req_o,
  output logic          fill_req_o,
  output logic [IW-1:0] xfer_cnt_o
);
  localparam int unsigned AW = IW + 2;
  localparam logic [AW-1:0] STK = AW'(NUM_REGS - NUM_GLOBAL);

  rsf_state_e    st_q, st_d;
  logic [IW-1:0] base_q, base_d, sof_q, sof_d, res_q, res_d;
  logic [IW-1:0] pk_q, pk_d, ps_q, ps_d, cnt_q, cnt_d;
  logic [AW-1:0] need;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] b, input logic [IW-1:0] k);
    logic [AW-1:0] s;
    s = AW'(b) + AW'(k);
    if (s >= STK) s = s - STK;
    return s[IW-1:0];
  endfunction

  function automatic logic [IW-1:0] wrap_sub(input logic [IW-1:0] b, input logic [IW-1:0] k);
    logic [AW-1:0] s;
    s = AW'(b) + STK - AW'(k);
    if (s >= STK) s = s - STK;
    return s[IW-1:0];
  endfunction

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    sof_d  = sof_q;
    res_d  = res_q;
    pk_d   = pk_q;
    ps_d   = ps_q;
    cnt_d  = cnt_q;
    need   = AW'(res_q) + AW'(call_keep_i) + AW'(call_size_i);
    unique case (st_q)
      ST_IDLE: begin
        if (call_i) begin
          if (need > STK) begin
            st_d  = ST_SPILL;
            pk_d  = call_keep_i;
            ps_d  = call_size_i;
            cnt_d = IW'(need - STK);
          end else begin
            base_d = wrap_add(base_q, call_keep_i);
            sof_d  = call_size_i;
            res_d  = res_q + call_keep_i;
          end
        end else if (ret_i) begin
          if (ret_keep_i > res_q) begin
            st_d  = ST_FILL;
            pk_d  = ret_keep_i;
            ps_d  = ret_size_i;
            cnt_d = ret_keep_i - res_q;
          end else begin
            base_d = wrap_sub(base_q, ret_keep_i);
            sof_d  = ret_size_i;
            res_d  = res_q - ret_keep_i;
          end
        end
      end
      ST_SPILL: if (xfer_ack_i) begin
        st_d   = ST_IDLE;
        base_d = wrap_add(base_q, pk_q);
        sof_d  = ps_q;
        res_d  = res_q - cnt_q + pk_q;
      end
      ST_FILL: if (xfer_ack_i) begin
        st_d   = ST_IDLE;
        base_d = wrap_sub(base_q, pk_q);
        sof_d  = ps_q;
        res_d  = res_q + cnt_q - pk_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      sof_q  <= '0;
      res_q  <= '0;
      pk_q   <= '0;
      ps_q   <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      sof_q  <= sof_d;
      res_q  <= res_d;
      pk_q   <= pk_d;
      ps_q   <= ps_d;
      cnt_q  <= cnt_d;
    end
  end

  assign base_o      = base_q;
  assign sof_o       = sof_q;
  assign res_o       = res_q;
  assign stall_o     = (st_q != ST_IDLE);
  assign spill_req_o = (st_q == ST_SPILL);
  assign fill_req_o  = (st_q == ST_FILL);
  assign xfer_cnt_o  = stall_o ? cnt_q : '0;
endmodule

// File: rtl/rsf_renamer.sv
module rsf_renamer #(
  parameter int unsigned NUM_REGS   = 128,
  parameter int unsigned NUM_GLOBAL = 32,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] lreg_i,
  output logic [IW-1:0] preg_o,
  output logic          ill_o,
  input  logic          call_i,
  input  logic [IW-1:0] call_keep_i,
  input  logic [IW-1:0] call_size_i,
  input  logic          ret_i,
  input  logic [IW-1:0] ret_keep_i,
  input  logic [IW-1:0] ret_size_i,
  input  logic          xfer_ack_i,
  output logic          stall_o,
  output logic          spill_req_o,
  output logic          fill_req_o,
  output logic [IW-1:0] xfer_cnt_o
);
  logic [IW-1:0] base_w, sof_w, res_w;

  rsf_frame #(.NUM_REGS(NUM_REGS), .NUM_GLOBAL(NUM_GLOBAL)) frame_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .call_keep_i (call_keep_i),
    .call_size_i (call_size_i),
    .ret_i       (ret_i),
    .ret_keep_i  (ret_keep_i),
    .ret_size_i  (ret_size_i),
    .xfer_ack_i  (xfer_ack_i),
    .base_o      (base_w),
    .sof_o       (sof_w),
    .res_o       (res_w),
    .stall_o     (stall_o),
    .spill_req_o (spill_req_o),
    .fill_req_o  (fill_req_o),
    .xfer_cnt_o  (xfer_cnt_o)
  );

  rsf_map #(.NUM_REGS(NUM_REGS), .NUM_GLOBAL(NUM_GLOBAL)) map_i (
    .lreg_i (lreg_i),
    .base_i (base_w),
    .sof_i  (sof_w),
    .preg_o (preg_o),
    .ill_o  (ill_o)
  );
endmodule

// File: rtl/rsf_renamer_chk.sv
module rsf_renamer_chk #(
  parameter int unsigned NUM_REGS   = 128,
  parameter int unsigned NUM_GLOBAL = 32,
  localparam int unsigned IW = $clog2(NUM_REGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] lreg_i,
  input logic [IW-1:0] preg_o,
  input logic          ill_o,
  input logic          call_i,
  input logic [IW-1:0] call_size_i,
  input logic          ret_i,
  input logic [IW-1:0] ret_size_i,
  input logic          xfer_ack_i,
  input logic          stall_o,
  input logic          spill_req_o,
  input logic          fill_req_o,
  input logic [IW-1:0] xfer_cnt_o,
  input logic [IW-1:0] base_w,
  input logic [IW-1:0] sof_w,
  input logic [IW-1:0] res_w
);
  localparam logic [IW:0] STK = (IW+1)'(NUM_REGS - NUM_GLOBAL);

  a_r2_global_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lreg_i < IW'(NUM_GLOBAL)) |-> (preg_o == lreg_i));

  a_r4_ill_only_stacked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_o |-> (lreg_i >= IW'(NUM_GLOBAL)));

  a_r5_call_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !stall_o) |=> (spill_req_o || sof_w == $past(call_size_i)));

  a_r6_ret_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !stall_o) |=> (fill_req_o || sof_w == $past(ret_size_i)));

  a_r6_capacity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, res_w} + {1'b0, sof_w}) <= STK);

  a_r7_req_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ((spill_req_o != fill_req_o) && xfer_cnt_o != '0));

  a_r7_spill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_req_o && !xfer_ack_i) |=> (spill_req_o && $stable(xfer_cnt_o)));

  a_r8_fill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !xfer_ack_i) |=> (fill_req_o && $stable(xfer_cnt_o)));

  a_r9_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && xfer_ack_i) |=> !stall_o);

  a_r10_frame_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !xfer_ack_i) |=> ($stable(base_w) && $stable(sof_w)));

  a_r1_idle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> (xfer_cnt_o == '0 && !spill_req_o && !fill_req_o));
endmodule

bind rsf_renamer rsf_renamer_chk #(.NUM_REGS(NUM_REGS), .NUM_GLOBAL(NUM_GLOBAL)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lreg_i      (lreg_i),
  .preg_o      (preg_o),
  .ill_o       (ill_o),
  .call_i      (call_i),
  .call_size_i (call_size_i),
  .ret_i       (ret_i),
  .ret_size_i  (ret_size_i),
  .xfer_ack_i  (xfer_ack_i),
  .stall_o     (stall_o),
  .spill_req_o (spill_req_o),
  .fill_req_o  (fill_req_o),
  .xfer_cnt_o  (xfer_cnt_o),
  .base_w      (base_w),
  .sof_w       (sof_w),
  .res_w       (res_w)
);

// File: tb/rsf_renamer_tb_top.sv
module rsf_renamer_tb_top;
  localparam int NS = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] lreg = '0, call_keep = '0, call_size = '0, ret_keep = '0, ret_size = '0;
  logic       call = 1'b0, ret = 1'b0, ack = 1'b0;
  logic [6:0] preg, cnt;
  logic       ill, stall, spill, fill;

  always #10 clk = ~clk;

  rsf_renamer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lreg_i(lreg), .preg_o(preg), .ill_o(ill),
    .call_i(call), .call_keep_i(call_keep), .call_size_i(call_size),
    .ret_i(ret), .ret_keep_i(ret_keep), .ret_size_i(ret_size),
    .xfer_ack_i(ack), .stall_o(stall), .spill_req_o(spill), .fill_req_o(fill),
    .xfer_cnt_o(cnt)
  );

  int checks = 0, fails = 0;
  int m_base = 0, m_sof = 0, m_res = 0, m_st = 0, m_cnt = 0, m_pk = 0, m_ps = 0;
  int stk_keep[$], stk_sof[$];
  int p, il;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_phys(input int l);
    if (l < 32) return l;
    return 32 + ((m_base + l - 32) % NS);
  endfunction

  task automatic model_step();
    int k, s;
    if (m_st == 0) begin
      if (call) begin
        k = int'(call_keep); s = int'(call_size);
        if (m_res + k + s > NS) begin
          m_st = 1; m_cnt = m_res + k + s - NS; m_pk = k; m_ps = s;
        end else begin
          m_base = (m_base + k) % NS; m_sof = s; m_res += k;
        end
      end else if (ret) begin
        k = int'(ret_keep); s = int'(ret_size);
        if (k > m_res) begin
          m_st = 2; m_cnt = k - m_res; m_pk = k; m_ps = s;
        end else begin
          m_base = (m_base - k + NS) % NS; m_sof = s; m_res -= k;
        end
      end
    end else if (ack) begin
      if (m_st == 1) begin
        m_res = m_res - m_cnt + m_pk; m_base = (m_base + m_pk) % NS;
      end else begin
        m_res = m_res + m_cnt - m_pk; m_base = (m_base - m_pk + NS) % NS;
      end
      m_sof = m_ps; m_st = 0;
    end
  endtask

  task automatic compare_all();
    int l;
    l = int'(lreg);
    chk(l < 32 ? "R2 preg" : "R3 preg", int'(preg), exp_phys(l));
    chk("R4 ill", int'(ill), (l >= 32 + m_sof) ? 1 : 0);
    chk("R7 spill_req", int'(spill), (m_st == 1) ? 1 : 0);
    chk("R8 fill_req", int'(fill), (m_st == 2) ? 1 : 0);
    chk("R10 stall", int'(stall), (m_st != 0) ? 1 : 0);
    chk("R9 xfer_cnt", int'(cnt), (m_st != 0) ? m_cnt : 0);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic probe(input int l, output int pp, output int ii);
    lreg = 7'(l);
    #1;
    pp = int'(preg);
    ii = int'(ill);
  endtask

  task automatic do_call(input int k, input int s);
    call = 1'b1; call_keep = 7'(k); call_size = 7'(s);
    cyc();
    call = 1'b0;
  endtask

  task automatic do_ret(input int k, input int s);
    ret = 1'b1; ret_keep = 7'(k); ret_size = 7'(s);
    cyc();
    ret = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    cyc();
    ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int pb;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stall", int'(stall), 0);
    chk("R1 spill", int'(spill), 0);
    chk("R1 fill", int'(fill), 0);
    chk("R1 cnt", int'(cnt), 0);
    probe(32, p, il); chk("R1 ill empty frame", il, 1);
    chk("R1 base0", p, 32);
    rst_n = 1'b1;
    cyc();

    // R5: first frame
    do_call(0, 20);
    probe(45, p, il); chk("R5 map", p, 45);
    probe(51, p, il); chk("R4 last legal", il, 0);
    probe(52, p, il); chk("R4 first illegal", il, 1);

    // R5: outgoing registers become callee's first registers
    probe(47, pb, il);
    do_call(12, 30);
    probe(35, p, il); chk("R5 argument pass", p, pb);
    probe(20, p, il); chk("R2 global", p, 20);

    // R7: call that overflows the region
    probe(40, pb, il); chk("R3 offset map", pb, 52);
    do_call(30, 80);
    chk("R7 spill_req", int'(spill), 1);
    chk("R7 count", int'(cnt), 26);
    chk("R7 stall", int'(stall), 1);
    probe(40, p, il); chk("R7 frame held", p, 52);

    // R10: strobes during stall are ignored
    call = 1'b1; call_keep = 7'd0; call_size = 7'd5;
    ret = 1'b1; ret_keep = 7'd3; ret_size = 7'd9;
    cyc();
    call = 1'b0; ret = 1'b0;
    chk("R10 still spilling", int'(spill), 1);
    chk("R10 count kept", int'(cnt), 26);

    // R9: ack completes held call
    do_ack();
    chk("R9 stall drop", int'(stall), 0);
    probe(32, p, il); chk("R9 new base", p, 74);
    probe(111, p, il); chk("R9 size last legal", il, 0);
    probe(112, p, il); chk("R9 size first illegal", il, 1);

    // R8: return needing a fill
    do_ret(30, 30);
    chk("R8 fill_req", int'(fill), 1);
    chk("R8 count", int'(cnt), 14);
    do_ack();
    probe(35, p, il); chk("R6 caller map restored", p, 47);
    probe(62, p, il); chk("R6 caller size", il, 1);

    do_ret(12, 20);
    chk("R8 count second", int'(cnt), 12);
    do_ack();
    probe(40, p, il); chk("R6 outer base", p, 40);

    // R10: call wins over return
    call = 1'b1; call_keep = 7'd5; call_size = 7'd10;
    ret = 1'b1; ret_keep = 7'd7; ret_size = 7'd33;
    cyc();
    call = 1'b0; ret = 1'b0;
    probe(41, p, il); chk("R10 call priority legal", il, 0);
    probe(42, p, il); chk("R10 call priority illegal", il, 1);
    probe(32, p, il); chk("R10 call priority base", p, 37);
    do_ret(5, 20);
    probe(32, p, il); chk("R6 ret no fill", p, 32);
    chk("R6 no stall", int'(stall), 0);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      lreg = 7'($urandom_range(0, 127));
      ack = 1'b0; call = 1'b0; ret = 1'b0;
      if (m_st != 0) begin
        ack = ($urandom_range(0, 2) == 0);
        call = $urandom_range(0, 1) == 1;
        ret = $urandom_range(0, 1) == 1;
        call_keep = 7'($urandom_range(0, 96));
        call_size = 7'($urandom_range(0, 96));
        ret_keep = 7'($urandom_range(0, 96));
        ret_size = 7'($urandom_range(0, 96));
      end else begin
        int sel, k, s;
        sel = $urandom_range(0, 9);
        if (sel < 3 && stk_keep.size() < 24) begin
          k = $urandom_range(0, m_sof);
          s = $urandom_range(0, 48);
          stk_keep.push_back(k); stk_sof.push_back(m_sof);
          call = 1'b1; call_keep = 7'(k); call_size = 7'(s);
        end else if (sel < 6 && stk_keep.size() > 0) begin
          ret = 1'b1;
          ret_keep = 7'(stk_keep.pop_back());
          ret_size = 7'(stk_sof.pop_back());
        end
      end
      cyc();
    end
    call = 1'b0; ret = 1'b0; ack = 1'b0;
    finish_run();
  end
endmodule